// File: doc/BRIEF.md
# Three-Channel Interval Timer

This block contains three 16-bit timer channels. They share one clock and one tick enable, and each has its own gate input and output line. A single-cycle write selects one channel and loads that channel's operating mode and reload count together. Every write restarts the channel's count of ticks since load.

Each channel's output is a pure function of two values: the elapsed ticks and the loaded count. Modes 0, 1, 4 and 5 are one-shot shapes, and their counter stops once the shape is complete. Modes 2 and 3 are periodic: a one-tick rate pulse and a square wave. A stored count of zero stands for 65536 ticks.

The gate is registered and exposed on `gate_state`. While the registered gate is low, the channel's elapsed counter is frozen. Reset puts every channel into square-wave mode with the full 65536-tick period. It enables the gates of channels 0 and 1 and holds the gate of channel 2 low.

Top module: `tri_interval_timer`

## Requirements
- R1: After reset, `timer_out` is 3'b111 (every channel in mode 3 with a count of 65536 and zero elapsed ticks), and `gate_state` is 3'b011.
- R2: A write with `wr_en`=1 and `wr_sel` = n (0..2) loads channel n on that edge and sets its elapsed count to 0. The elapsed count then rises by one on each later edge where `tick_en`=1 and `gate_state[n]`=1. `gate_state` is `gate_in` delayed by one cycle. With no write and `tick_en`=0, no output changes.
- R3: Mode 0 (`wr_mode`=3'd0): the output is low while elapsed < count and high once elapsed >= count.
- R4: Mode 1 (`wr_mode`=3'd1): the output is high while elapsed < count and low from then on.
- R5: Mode 2 (`wr_mode`=3'd2): the output is high only when elapsed is a nonzero multiple of the count. It is low at elapsed 0.
- R6: Mode 3 (`wr_mode`=3'd3): the output is high when (elapsed mod count) < (count+1)/2, rounded down. For an odd count, the high phase is one tick longer than the low phase.
- R7: Modes 4 and 5 (`wr_mode`=3'd4, 3'd5): the output is high only on the tick where elapsed equals the count.
- R8: A written count of 0 acts as 65536 ticks.
- R9: `wr_mode` code 6 behaves as mode 2, and code 7 behaves as mode 3.
- R10: A write with `wr_sel`=3 changes nothing. A write to one channel leaves the elapsed count and output of the other channels unchanged.
- R11: In modes 0, 1, 4 and 5, the output keeps its final level indefinitely once the count is passed, so the shape does not repeat.
- R12: While `gate_state[n]`=0, channel n's elapsed count does not advance, even when `tick_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Shared timer tick enable |
| gate_in | input | 3 | Per-channel gate inputs |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Channel select (3 selects nothing) |
| wr_mode | input | 3 | Mode code |
| wr_count | input | 16 | Reload count (0 means 65536) |
| gate_state | output | 3 | Registered gate per channel |
| timer_out | output | 3 | Channel outputs |

## Verification
The assertions assume three things: `gate_in`, `tick_en` and the write fields are valid on every edge after reset, a channel's mode changes only through a write, and the counts are nonzero after the zero-to-65536 mapping. These assumptions let the load-level, pause and idle properties relate outputs only to the previous cycle's inputs. The stimulus changes inputs only at falling edges. It lowers `tick_en` during every write, and it changes a gate with `tick_en` low, so the one-cycle gate delay never overlaps a counted tick.

// File: rtl/itimer_pkg.sv
// Shared types for the interval timer: mode encoding and mode canonicalisation.
// Assumes a 3-bit mode code on the write port.
package itimer_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        TM_LATCH_HIGH = 3'd0,
        TM_PULSE_LOW  = 3'd1,
        TM_RATE       = 3'd2,
        TM_SQUARE     = 3'd3,
        TM_STROBE_A   = 3'd4,
        TM_STROBE_B   = 3'd5
    } tm_mode_e;

    // Map the two spare codes (6 and 7) onto the periodic modes 2 and 3.
    function automatic tm_mode_e canon_mode(input logic [MODE_W-1:0] code);
        if (code[2:1] == 2'b11) begin
            return tm_mode_e'({1'b0, code[1:0]});
        end
        return tm_mode_e'(code);
    endfunction

    // True for modes whose elapsed count wraps at the period.
    function automatic logic is_periodic(input tm_mode_e m);
        return (m == TM_RATE) || (m == TM_SQUARE);
    endfunction

endpackage

// File: rtl/itimer_elapsed.sv
// Elapsed-tick counter of one channel.
// In periodic modes it wraps at the effective count and remembers that it has
// wrapped at least once; in one-shot modes it saturates one past the count.
// Assumes eff_count is in 1..2**(ELW-1) and stays constant between loads.
module itimer_elapsed #(
    parameter int ELW = 17
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           advance,
    input  logic           periodic,
    input  logic [ELW-1:0] eff_count,
    output logic [ELW-1:0] elapsed,
    output logic           wrapped
);

    logic [ELW-1:0] last_phase;

    // Last phase value before a periodic wrap.
    always_comb last_phase = eff_count - ELW'(1);

    // Count ticks since load, wrapping or saturating according to the mode class.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            elapsed <= '0;
            wrapped <= 1'b0;
        end else if (advance) begin
            if (periodic) begin
                if (elapsed == last_phase) begin
                    elapsed <= '0;
                    wrapped <= 1'b1;
                end else begin
                    elapsed <= elapsed + ELW'(1);
                end
            end else if (elapsed <= eff_count) begin
                elapsed <= elapsed + ELW'(1);
            end
        end
    end

endmodule

// File: rtl/itimer_wave.sv
// Output decoder of one channel: a pure function of the mode, the effective
// count and the elapsed ticks (phase within the period in periodic modes).
// Assumes the elapsed value comes from itimer_elapsed under the same mode.
module itimer_wave
    import itimer_pkg::*;
#(
    parameter int ELW = 17
) (
    input  tm_mode_e       mode,
    input  logic [ELW-1:0] eff_count,
    input  logic [ELW-1:0] elapsed,
    input  logic           wrapped,
    output logic           wave
);

    logic [ELW-1:0] high_len;

    // High-phase length of the square wave, with the odd tick on the high side.
    always_comb high_len = (eff_count + ELW'(1)) >> 1;

    // Select the output shape for the current mode.
    always_comb begin
        unique case (mode)
            TM_LATCH_HIGH: wave = (elapsed >= eff_count);
            TM_PULSE_LOW:  wave = (elapsed <  eff_count);
            TM_RATE:       wave = wrapped && (elapsed == '0);
            TM_SQUARE:     wave = (elapsed < high_len);
            TM_STROBE_A,
            TM_STROBE_B:   wave = (elapsed == eff_count);
            default:       wave = 1'b0;
        endcase
    end

endmodule

// File: rtl/itimer_channel.sv
// One timer channel: holds the mode and reload count, and drives the
// elapsed counter and the output decoder.
// Assumes load is a one-cycle strobe and that advance already includes the gate.
module itimer_channel
    import itimer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  tm_mode_e         load_mode,
    input  logic [CNT_W-1:0] load_count,
    input  logic             advance,
    output logic             wave
);

    localparam int ELW = CNT_W + 1;

    tm_mode_e       mode_q;
    logic [CNT_W-1:0] count_q;
    logic [ELW-1:0] eff_count;
    logic [ELW-1:0] elapsed;
    logic           wrapped;

    // Hold the programmed mode and count; reset gives the full-period square wave.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= TM_SQUARE;
            count_q <= '0;
        end else if (load) begin
            mode_q  <= load_mode;
            count_q <= load_count;
        end
    end

    // A stored zero stands for the largest period.
    always_comb eff_count = (count_q == '0) ? (ELW'(1) << CNT_W) : {1'b0, count_q};

    itimer_elapsed #(.ELW(ELW)) u_elapsed (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .advance   (advance),
        .periodic  (is_periodic(mode_q)),
        .eff_count (eff_count),
        .elapsed   (elapsed),
        .wrapped   (wrapped)
    );

    itimer_wave #(.ELW(ELW)) u_wave (
        .mode      (mode_q),
        .eff_count (eff_count),
        .elapsed   (elapsed),
        .wrapped   (wrapped),
        .wave      (wave)
    );

endmodule

// File: rtl/tri_interval_timer.sv
// Multi-channel interval timer top: registers the gates, decodes the write
// port into per-channel loads and instantiates one channel per output.
// Assumes wr_sel values at or above NUM_CH select no channel.
module tri_interval_timer
    import itimer_pkg::*;
#(
    parameter int          NUM_CH   = 3,
    parameter int          CNT_W    = 16,
    parameter logic [NUM_CH-1:0] GATE_RST = 3'b011,
    localparam int         SEL_W    = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [NUM_CH-1:0] gate_in,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [MODE_W-1:0] wr_mode,
    input  logic [CNT_W-1:0]  wr_count,
    output logic [NUM_CH-1:0] gate_state,
    output logic [NUM_CH-1:0] timer_out
);

    tm_mode_e wr_mode_c;

    // Fold the spare mode codes before they reach the channels.
    always_comb wr_mode_c = canon_mode(wr_mode);

    // Register the gate inputs; reset applies the per-channel defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_state <= GATE_RST;
        else        gate_state <= gate_in;
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic load_ch;

        // Load strobe for this channel only.
        always_comb load_ch = wr_en && (wr_sel == SEL_W'(ch));

        itimer_channel #(.CNT_W(CNT_W)) u_channel (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (load_ch),
            .load_mode  (wr_mode_c),
            .load_count (wr_count),
            .advance    (tick_en && gate_state[ch]),
            .wave       (timer_out[ch])
        );
    end

endmodule

// File: rtl/itimer_checker.sv
// Assertion checker for tri_interval_timer, bound to every instance.
module itimer_checker #(
    parameter int          NUM_CH   = 3,
    parameter int          SEL_W    = 2,
    parameter logic [NUM_CH-1:0] GATE_RST = 3'b011
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic [NUM_CH-1:0] gate_in,
    input logic              wr_en,
    input logic [SEL_W-1:0]  wr_sel,
    input logic [2:0]        wr_mode,
    input logic [NUM_CH-1:0] gate_state,
    input logic [NUM_CH-1:0] timer_out
);

    // R1: the cycle after reset shows the default gates and all outputs high.
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (gate_state == GATE_RST) && (timer_out == '1));

    // R2: the registered gate is the gate input one cycle later.
    a_r2_gate_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> gate_state == $past(gate_in));

    // R2: with no tick and no write, the outputs hold.
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !wr_en) |=> $stable(timer_out));

    // R10: a write to an unused select with no tick changes nothing.
    a_r10_bad_select: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_sel) >= NUM_CH) && !tick_en) |=> $stable(timer_out));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R12: a closed gate freezes the channel output.
        a_r12_gate_freeze: assert property (@(posedge clk) disable iff (!rst_n)
            (!gate_state[i] && !wr_en) |=> $stable(timer_out[i]));

        // R4, R6, R9: modes 1, 3 and 7 start high right after a load.
        a_r9_load_high: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (int'(wr_sel) == i) && (wr_mode inside {3'd1, 3'd3, 3'd7}))
            |=> timer_out[i]);

        // R3, R5, R7, R9: modes 0, 2, 4, 5 and 6 start low right after a load.
        a_r3_load_low: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (int'(wr_sel) == i) && (wr_mode inside {3'd0, 3'd2, 3'd4, 3'd5, 3'd6}))
            |=> !timer_out[i]);
    end

endmodule

bind tri_interval_timer itimer_checker #(
    .NUM_CH   (NUM_CH),
    .SEL_W    (SEL_W),
    .GATE_RST (GATE_RST)
) u_itimer_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .gate_in    (gate_in),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_mode    (wr_mode),
    .gate_state (gate_state),
    .timer_out  (timer_out)
);

// File: tb/tri_interval_timer_test.sv
// Directed bench: each task programs a scenario and checks its own results.
module tri_interval_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [2:0]  gate_in = 3'b011;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [2:0]  wr_mode = '0;
    logic [15:0] wr_count = '0;
    logic [2:0]  gate_state;
    logic [2:0]  timer_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tri_interval_timer uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .gate_in    (gate_in),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_mode    (wr_mode),
        .wr_count   (wr_count),
        .gate_state (gate_state),
        .timer_out  (timer_out)
    );

    // Expected output from the requirements: k ticks since load.
    function automatic logic ref_out(input int mode, input int cnt, input int k);
        int eff = (cnt == 0) ? 65536 : cnt;
        int m = (mode >= 6) ? mode - 4 : mode;
        case (m)
            0: return k >= eff;
            1: return k < eff;
            2: return (k != 0) && (k % eff == 0);
            3: return (k % eff) < ((eff + 1) / 2);
            default: return k == eff;
        endcase
    endfunction

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_ch(input string req, input int ch, input logic exp);
        check(req, {2'b00, timer_out[ch]}, {2'b00, exp});
    endtask

    // One-cycle write with ticks off; returns at the falling edge after the load.
    task automatic wr(input int sel, input int mode, input int cnt);
        @(negedge clk);
        tick_en  = 1'b0;
        wr_en    = 1'b1;
        wr_sel   = 2'(sel);
        wr_mode  = 3'(mode);
        wr_count = 16'(cnt);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Apply n counted ticks; returns at a falling edge with ticks off.
    task automatic adv(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
        end
        tick_en = 1'b0;
    endtask

    // Program a channel and compare its output over n ticks with the model.
    task automatic sweep(input string req, input int ch, input int mode, input int cnt, input int n);
        wr(ch, mode, cnt);
        for (int k = 0; k <= n; k++) begin
            check_ch(req, ch, ref_out(mode, cnt, k));
            if (k < n) adv(1);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1", timer_out, 3'b111);
        check("R1", gate_state, 3'b011);
        adv(32767);
        check("R1", timer_out, 3'b111);
        adv(1);
        // R12: channel 2 gate is closed, so only channels 0 and 1 reach the low half.
        check("R12", timer_out, 3'b100);
    endtask

    task automatic t_modes;
        sweep("R3", 0, 0, 5, 8);
        sweep("R4", 1, 1, 4, 7);
        sweep("R5", 0, 2, 3, 10);
        sweep("R5", 1, 2, 1, 4);
        sweep("R6", 0, 3, 5, 12);
        sweep("R6", 1, 3, 4, 10);
        sweep("R6", 0, 3, 1, 3);
        sweep("R7", 0, 4, 3, 8);
        sweep("R7", 1, 5, 2, 6);
    endtask

    task automatic t_alias;
        sweep("R9", 0, 6, 3, 10);
        sweep("R9", 1, 7, 5, 12);
    endtask

    task automatic t_restart_and_idle;
        wr(0, 0, 3);
        adv(2);
        wr(0, 0, 3);
        adv(2);
        check_ch("R2", 0, 1'b0);
        repeat (5) @(negedge clk);
        check_ch("R2", 0, 1'b0);
        adv(1);
        check_ch("R2", 0, 1'b1);
    endtask

    task automatic t_select;
        wr(0, 0, 4);
        adv(2);
        wr(3, 1, 1);
        wr(1, 1, 9);
        adv(1);
        check_ch("R10", 0, 1'b0);
        adv(1);
        check_ch("R10", 0, 1'b1);
        check_ch("R10", 1, 1'b1);
    endtask

    task automatic t_saturate;
        wr(0, 4, 2);
        wr(1, 0, 2);
        adv(2);
        check_ch("R11", 0, 1'b1);
        for (int i = 0; i < 300; i++) begin
            adv(1);
            check("R11", {1'b0, timer_out[1:0]}, 3'b010);
        end
    endtask

    task automatic t_gate;
        wr(2, 0, 3);
        adv(5);
        check_ch("R12", 2, 1'b0);
        gate_in[2] = 1'b1;
        @(negedge clk);
        check("R2", gate_state, 3'b111);
        adv(2);
        check_ch("R12", 2, 1'b0);
        adv(1);
        check_ch("R12", 2, 1'b1);
    endtask

    task automatic t_zero_count;
        wr(1, 4, 0);
        adv(65535);
        check_ch("R8", 1, 1'b0);
        adv(1);
        check_ch("R8", 1, 1'b1);
        adv(1);
        check_ch("R8", 1, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_modes();
        t_alias();
        t_restart_and_idle();
        t_select();
        t_saturate();
        t_gate();
        t_zero_count();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(180000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule